// File: doc/BRIEF.md
# Pseudorandom Bit-Stream Error Tester

This block measures the bit error rate of a serial link without any synchronisation between the two ends. Its transmit half is a maximal-length linear feedback shift register. Each time the transmit half is enabled, it emits one pseudorandom bit. A single-cycle inject input flips one emitted bit, so that a deliberate error can be placed on the link.

Its receive half keeps a short history of the bits it has received. It XORs each new bit with the history bits that sit at the generator's feedback positions. On an error-free stream this combination is always zero, whatever phase the stream is in. Each nonzero result is counted as an error, and a second counter totals the received bits.

A channel bit error appears in every one of the three terms of the combination, so the error count is about three times the number of channel errors. A later stage divides by three to get the rate. Both counters saturate at their maximum value and are cleared by a synchronous reset.

Top module: `prbs_ber_tester`

## Requirements
- R1: While `rst` is high at a clock edge, `tx_bit`, `err_pulse`, `bit_total` and `err_total` become 0. The generator state is loaded with `SEED`, and the receive history is marked empty.
- R2: On each edge with `tx_en` high, the generator forms a new bit as the XOR of state bits `TAP_A-1` and `TAP_B-1`, then shifts that bit into state bit 0. `tx_bit` takes the new bit in the same edge. With the default taps 15 and 14 the emitted sequence satisfies y[n] = y[n-15] XOR y[n-14] and repeats with period 32767.
- R3: A loop-back of `tx_bit` into `rx_bit`, one received bit per emitted bit, leaves `err_total` at 0.
- R4: The first `LFSR_W` received bits after reset are never counted as errors, but each is counted in `bit_total`.
- R5: Each edge with `rx_en` high adds 1 to `bit_total`. Once it reaches 2^`CNT_W`-1 it stays there.
- R6: The annihilator output is `rx_bit` XOR the bits received `TAP_A` and `TAP_B` bits earlier. On each edge where `rx_en` is high, the history is full and that output is 1, `err_total` rises by 1 (saturating) and `err_pulse` is 1 for the following cycle. Otherwise `err_pulse` is 0.
- R7: One bit flipped by `inj_err` in an otherwise clean loop-back stream, once the history is full, raises `err_total` by exactly 3.
- R8: While `tx_en` is low, `tx_bit` holds its value and `inj_err` has no effect.
- R9: While `rx_en` is low, `bit_total` and `err_total` do not change, whatever `rx_bit` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Advance the generator by one bit |
| inj_err | input | 1 | Invert the bit emitted in this step |
| rx_en | input | 1 | `rx_bit` is valid this cycle |
| rx_bit | input | 1 | Received bit |
| tx_bit | output | 1 | Emitted pseudorandom bit (registered) |
| err_pulse | output | 1 | The previous received bit was counted as an error |
| bit_total | output | CNT_W | Saturating count of received bits |
| err_total | output | CNT_W | Saturating count of nonzero annihilator outputs |

## Verification
The bench places one injected error on a clean stream and expects a rise of exactly three. A design with a wrong tap or a misaligned history would show one, two or a steady stream of errors instead.

It feeds garbage during the warm-up window and checks that nothing is counted until the sixteenth bit. An off-by-one fill counter would count one bit early or one bit late.

It runs the generator for a full period to confirm the repeat at 32767 steps, which a wrong tap pair would break. It also drives an all-ones stream into narrow counters to check that both stop at their maximum rather than wrapping.

// File: rtl/prbs_ber_pkg.sv
package prbs_ber_pkg;
  localparam int DEF_LFSR_W = 15;
  localparam int DEF_TAP_A  = 15;
  localparam int DEF_TAP_B  = 14;
  localparam int DEF_CNT_W  = 32;
  localparam logic [DEF_LFSR_W-1:0] DEF_SEED = 15'h4A5B;
endpackage

// File: rtl/prbs_gen.sv
module prbs_gen #(
  parameter int W     = 15,
  parameter int TAP_A = 15,
  parameter int TAP_B = 14,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic flip,
  output logic bit_o
);
  logic [W-1:0] state;
  logic         fb;

  assign fb = state[TAP_A-1] ^ state[TAP_B-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
      bit_o <= 1'b0;
    end else if (step) begin
      state <= {state[W-2:0], fb};
      bit_o <= fb ^ flip;
    end
  end
endmodule

// File: rtl/prbs_annihilator.sv
module prbs_annihilator #(
  parameter int W     = 15,
  parameter int TAP_A = 15,
  parameter int TAP_B = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic din,
  output logic syndrome,
  output logic primed
);
  localparam int FILL_W = $clog2(W + 1);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(W);

  logic [W-1:0]      hist;
  logic [FILL_W-1:0] fill;

  assign syndrome = din ^ hist[TAP_A-1] ^ hist[TAP_B-1];
  assign primed   = (fill == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      fill <= '0;
    end else if (valid) begin
      hist <= {hist[W-2:0], din};
      if (!primed) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                    count <= '0;
    else if (inc && !(&count))  count <= count + 1'b1;
  end
endmodule

// File: rtl/prbs_ber_tester.sv
module prbs_ber_tester
  import prbs_ber_pkg::*;
#(
  parameter int LFSR_W = DEF_LFSR_W,
  parameter int TAP_A  = DEF_TAP_A,
  parameter int TAP_B  = DEF_TAP_B,
  parameter logic [LFSR_W-1:0] SEED = DEF_SEED,
  parameter int CNT_W  = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             inj_err,
  input  logic             rx_en,
  input  logic             rx_bit,
  output logic             tx_bit,
  output logic             err_pulse,
  output logic [CNT_W-1:0] bit_total,
  output logic [CNT_W-1:0] err_total
);
  logic syndrome, primed, hit;

  prbs_gen #(.W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .SEED(SEED)) u_gen (
    .clk(clk), .rst(rst), .step(tx_en), .flip(inj_err), .bit_o(tx_bit)
  );

  prbs_annihilator #(.W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_ann (
    .clk(clk), .rst(rst), .valid(rx_en), .din(rx_bit),
    .syndrome(syndrome), .primed(primed)
  );

  assign hit = rx_en && primed && syndrome;

  sat_counter #(.W(CNT_W)) u_bits (
    .clk(clk), .rst(rst), .inc(rx_en), .count(bit_total)
  );

  sat_counter #(.W(CNT_W)) u_errs (
    .clk(clk), .rst(rst), .inc(hit), .count(err_total)
  );

  always_ff @(posedge clk) begin
    if (rst) err_pulse <= 1'b0;
    else     err_pulse <= hit;
  end
endmodule

// File: rtl/prbs_ber_chk.sv
module prbs_ber_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_en,
  input logic             rx_en,
  input logic             tx_bit,
  input logic             err_pulse,
  input logic [CNT_W-1:0] bit_total,
  input logic [CNT_W-1:0] err_total
);
  // R5
  bits_step_chk: assert property (@(posedge clk) disable iff (rst)
    rx_en |=> (bit_total == $past(bit_total) + 1'b1) || (&bit_total));

  // R9
  rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> ($stable(bit_total) && $stable(err_total)));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> $stable(tx_bit));

  // R6
  pulse_count_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> ((err_total != $past(err_total)) || (&err_total)));

  // R6
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(rx_en));

  // R4
  err_le_bits_chk: assert property (@(posedge clk) disable iff (rst)
    err_total <= bit_total);
endmodule

bind prbs_ber_tester prbs_ber_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .tx_bit(tx_bit),
  .err_pulse(err_pulse), .bit_total(bit_total), .err_total(err_total)
);

// File: tb/prbs_ber_tester_bench.sv
module prbs_ber_tester_bench;
  localparam int CW  = 8;
  localparam int MAX = (1 << CW) - 1;
  localparam int PER = 32767;
  localparam logic [14:0] SEED = 15'h4A5B;

  logic clk = 0, rst = 1, tx_en = 0, inj_err = 0, rx_en = 0, rx_bit = 0;
  logic tx_bit, err_pulse;
  logic [CW-1:0] bit_total, err_total;

  int checks = 0, fails = 0, cycles = 0;
  logic gq[$];
  logic rq[$];
  logic e_tx, e_pulse;
  int e_bits, e_errs, tx_idx;
  logic first_bits[20];

  prbs_ber_tester #(.CNT_W(CW), .SEED(SEED)) u_prbs_ber_tester (
    .clk(clk), .rst(rst), .tx_en(tx_en), .inj_err(inj_err), .rx_en(rx_en),
    .rx_bit(rx_bit), .tx_bit(tx_bit), .err_pulse(err_pulse),
    .bit_total(bit_total), .err_total(err_total)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    gq.delete(); rq.delete();
    for (int i = 14; i >= 0; i--) gq.push_back(SEED[i]);
    e_tx = 0; e_pulse = 0; e_bits = 0; e_errs = 0; tx_idx = 0;
  endtask

  task automatic model_step(logic te, logic inj, logic re, logic rb);
    logic nb, c;
    if (te) begin
      nb = gq[0] ^ gq[1];
      void'(gq.pop_front());
      gq.push_back(nb);
      e_tx = nb ^ inj;
    end
    e_pulse = 0;
    if (re) begin
      if (e_bits < MAX) e_bits++;
      if (rq.size() == 15) begin
        c = rb ^ rq[0] ^ rq[1];
        if (c) begin
          e_pulse = 1;
          if (e_errs < MAX) e_errs++;
        end
      end
      rq.push_back(rb);
      if (rq.size() > 15) void'(rq.pop_front());
    end
  endtask

  // Called at a negedge; drives inputs, steps one clock, compares at next negedge.
  task automatic cyc(logic te, logic inj, logic re, logic rb);
    tx_en = te; inj_err = inj; rx_en = re; rx_bit = rb;
    @(posedge clk);
    model_step(te, inj, re, rb);
    @(negedge clk);
    chk("R2 tx_bit", tx_bit, e_tx);
    chk("R5 bit_total", bit_total, e_bits);
    chk("R6 err_total", err_total, e_errs);
    chk("R6 err_pulse", err_pulse, e_pulse);
    if (te) begin
      if (tx_idx < 20) first_bits[tx_idx] = tx_bit;
      else if (tx_idx >= PER && tx_idx < PER + 20)
        chk("R2 period", tx_bit, first_bits[tx_idx - PER]);
      tx_idx++;
    end
  endtask

  task automatic do_reset();
    rst = 1; tx_en = 0; inj_err = 0; rx_en = 0; rx_bit = 0;
    @(posedge clk); @(posedge clk);
    model_reset();
    @(negedge clk);
    chk("R1 tx_bit", tx_bit, 0);
    chk("R1 bit_total", bit_total, 0);
    chk("R1 err_total", err_total, 0);
    chk("R1 err_pulse", err_pulse, 0);
    rst = 0;
  endtask

  // Loop-back: the bit emitted last cycle is received while the next is emitted.
  task automatic loop(int n, logic inj_first);
    for (int i = 0; i < n; i++) cyc(1'b1, inj_first && i == 0, 1'b1, tx_bit);
  endtask

  initial begin
    int base, hold;
    @(negedge clk);
    do_reset();
    cyc(1, 0, 0, 0);
    loop(40, 0);
    chk("R3 clean stream errors", err_total, 0);

    base = err_total;
    loop(1, 1);
    loop(20, 0);
    chk("R7 injected error delta", err_total - base, 3);

    hold = tx_bit;
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, i[0]);
    chk("R8 tx_bit held with inj_err", tx_bit, hold);
    chk("R9 bits unchanged idle", bit_total, 61);
    chk("R9 errs unchanged idle", err_total, 3);

    loop(PER + 30, 0);
    chk("R5 bit_total saturated", bit_total, MAX);
    chk("R3 no new errors over period", err_total, 3);

    do_reset();
    for (int i = 0; i < 15; i++) cyc(0, 0, 1, 1);
    chk("R4 warm-up not counted", err_total, 0);
    chk("R4 warm-up bits counted", bit_total, 15);
    cyc(0, 0, 1, 1);
    chk("R4 first counted bit", err_total, 1);
    for (int i = 0; i < 300; i++) cyc(0, 0, 1, 1);
    chk("R6 err_total saturated", err_total, MAX);
    chk("R5 bit_total saturated", bit_total, MAX);
    finish_run();
  end
endmodule